// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block caches virtual-to-physical page translations in front of a hardware page table walker. Each lookup gives a 36-bit virtual page number (4 KB granularity), whether the access is a write, and whether it comes from user mode. One cycle later the block answers with exactly one outcome. A hit carries a 40-bit physical frame number. A protection fault means a cached mapping exists but denies the access. A miss tells the walker to fetch the translation and load it through the refill port.

Translations of three page sizes live in three separate arrays, and all three are probed in the same cycle. The 4 KB array has 16 sets of 4 ways. The 2 MB array is fully associative with 8 entries. The 1 GB array is fully associative with 4 entries. Loading the page table root clears every entry. A single-page invalidate removes any entry in any array whose page covers the given address. Each entry keeps a user-access bit, a writable bit and a dirty bit. A permitted write to a clean entry is answered as a miss, so that the walker can mark the page table entry dirty and then refill it.

Top module: `xlt_tlb`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_miss` are low and every array is empty, so every lookup misses until a refill is made.
- R2: A lookup with `lk_valid` high gets its response in the next cycle. `rsp_valid` is high in that cycle, and exactly one of `rsp_hit`, `rsp_fault` and `rsp_miss` is high. With no lookup, all four outputs are low. The lookup sees the contents as they were before any refill, invalidate or root load in the same cycle.
- R3: With `fill_size` = 0 the refill goes to the 4 KB array. That array has 16 sets of 4 ways, and the set is chosen by `vpn[3:0]`. A later lookup of the same page number hits and returns `fill_ppn` unchanged.
- R4: With `fill_size` = 1 the refill goes to the 2 MB array, which is fully associative with 8 entries and matches on `vpn[35:9]`. On a hit, `rsp_ppn` is `{fill_ppn[39:9], lk_vpn[8:0]}`, so the low 9 bits of the refilled frame are ignored.
- R5: With `fill_size` = 2 the refill goes to the 1 GB array, which is fully associative with 4 entries and matches on `vpn[35:18]`. On a hit, `rsp_ppn` is `{fill_ppn[39:18], lk_vpn[17:0]}`.
- R6: A matching entry gives a fault when `lk_user` is high and the entry's user bit is clear, or when `lk_write` is high and its writable bit is clear. A fault takes precedence over the dirty rule in R7, and it is not a miss.
- R7: A permitted write that matches an entry whose dirty bit is clear is answered as a miss. A read of the same entry is a hit.
- R8: `root_load` clears every entry in all three arrays, and a refill in the same cycle is discarded.
- R9: `inv_en` clears every entry in all three arrays whose page covers `inv_vpn` and leaves all other entries in place. A refill in the same cycle is still written.
- R10: A refill whose page number already matches an entry in its array overwrites that entry. Otherwise it takes the lowest-numbered empty way of the set. If the set is full, it evicts the way named by that set's round-robin pointer, which starts at 0 and advances by one only on such an eviction.
- R11: If more than one array matches a lookup, the 4 KB entry is used first, then the 2 MB entry, then the 1 GB entry.
- R12: A refill with `fill_size` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 36 | Virtual page number to translate |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup comes from user mode |
| rsp_valid | output | 1 | Response present (one cycle after lookup) |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_fault | output | 1 | Translation found but access denied |
| rsp_miss | output | 1 | Walker must supply the translation |
| rsp_ppn | output | 40 | Physical frame number on a hit |
| fill_en | input | 1 | Refill from the walker |
| fill_size | input | 2 | Page size of the refill: 0=4 KB, 1=2 MB, 2=1 GB |
| fill_vpn | input | 36 | Virtual page number of the refill |
| fill_ppn | input | 40 | Physical frame number of the refill |
| fill_user | input | 1 | Refilled page is user-accessible |
| fill_write | input | 1 | Refilled page is writable |
| fill_dirty | input | 1 | Refilled page is already dirty |
| inv_en | input | 1 | Invalidate the translations covering `inv_vpn` |
| inv_vpn | input | 36 | Page number to invalidate |
| root_load | input | 1 | Page table root written: clear everything |

## Verification
A lookup can land in the same cycle as an invalidate or a root load that removes the entry being looked up. A lookup can also land in the same cycle as a refill of the address it asks for. The directed phase places these pairs deliberately: an invalidate of a cached 2 MB page together with a lookup of that page, a root load together with a lookup and a refill, and a refill together with a lookup of its own address. The bench then judges the response against the state before the update, and the lookup in the following cycle against the state after it. A long random phase draws addresses from a small pool, so that lookups, refills, invalidates and root loads keep colliding in the same cycles. Every cycle is compared against a behavioural model.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  // Per-entry access rights and modification state
  typedef struct packed {
    logic usr;
    logic wr;
    logic dirty;
  } xlt_perm_t;

  // Refill page size code carried on fill_size
  typedef enum logic [1:0] {
    SZ_4K   = 2'd0,
    SZ_2M   = 2'd1,
    SZ_1G   = 2'd2,
    SZ_NONE = 2'd3
  } xlt_size_e;

  // Page-number bits consumed by one level of the radix tree
  localparam int unsigned LVL_BITS = 9;

endpackage

// File: rtl/xlt_victim.sv
// Chooses the way a refill writes: the matching way, else the lowest
// empty way, else the round-robin pointer (WAYS must be a power of two).
module xlt_victim #(
  parameter  int unsigned WAYS  = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  same_key,
  input  logic [WAYS-1:0]  occupied,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] way,
  output logic             evict
);

  always_comb begin
    way   = rr_ptr;
    evict = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!occupied[w]) begin
        way   = WAY_W'(w);
        evict = 1'b0;
      end
    end
    if (|same_key) begin
      evict = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (same_key[w]) way = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/xlt_bank.sv
// One associative translation array for one page size.
// KEY_W is the page-number width at this size; SETS=1 gives a fully
// associative array.
module xlt_bank
  import xlt_pkg::*;
#(
  parameter  int unsigned KEY_W  = 36,
  parameter  int unsigned FRM_W  = 40,
  parameter  int unsigned SETS   = 16,
  parameter  int unsigned WAYS   = 4,
  localparam int unsigned IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned IDX_B  = (SETS > 1) ? IDX_W : 0,
  localparam int unsigned SETS_P = 1 << IDX_W,
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned TAG_W  = KEY_W - IDX_B
) (
  input  logic             clk,
  input  logic             rst_n,
  // probe
  input  logic [KEY_W-1:0] probe_key,
  output logic             probe_hit,
  output logic [FRM_W-1:0] probe_frm,
  output xlt_perm_t        probe_perm,
  // maintenance
  input  logic             flush,
  input  logic             inv_en,
  input  logic [KEY_W-1:0] inv_key,
  // refill
  input  logic             fill_en,
  input  logic [KEY_W-1:0] fill_key,
  input  logic [FRM_W-1:0] fill_frm,
  input  xlt_perm_t        fill_perm
);

  function automatic logic [IDX_W-1:0] idx_of(input logic [KEY_W-1:0] k);
    return (SETS > 1) ? IDX_W'(k) : '0;
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [KEY_W-1:0] k);
    return TAG_W'(k >> IDX_B);
  endfunction

  // state
  logic [SETS_P-1:0][WAYS-1:0]  vld_q, vld_d;
  logic [SETS_P-1:0][WAY_W-1:0] rr_q, rr_d;
  logic [TAG_W-1:0]             tag_q  [SETS_P][WAYS];
  logic [FRM_W-1:0]             frm_q  [SETS_P][WAYS];
  xlt_perm_t                    perm_q [SETS_P][WAYS];

  logic [IDX_W-1:0] p_idx, i_idx, f_idx;
  logic [TAG_W-1:0] p_tag, i_tag, f_tag;
  logic [WAYS-1:0]  inv_hit, fill_same, fill_occ;
  logic [WAY_W-1:0] v_way;
  logic             v_evict;
  logic             wr_en;

  assign p_idx = idx_of(probe_key);
  assign p_tag = tag_of(probe_key);
  assign i_idx = idx_of(inv_key);
  assign i_tag = tag_of(inv_key);
  assign f_idx = idx_of(fill_key);
  assign f_tag = tag_of(fill_key);

  // per-way compare for invalidate and refill
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign inv_hit[w]   = vld_q[i_idx][w] && (tag_q[i_idx][w] == i_tag);
    assign fill_same[w] = vld_q[f_idx][w] && (tag_q[f_idx][w] == f_tag);
    assign fill_occ[w]  = vld_q[f_idx][w];
  end

  // probe: lowest matching way wins
  always_comb begin
    probe_hit  = 1'b0;
    probe_frm  = '0;
    probe_perm = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[p_idx][w] && (tag_q[p_idx][w] == p_tag)) begin
        probe_hit  = 1'b1;
        probe_frm  = frm_q[p_idx][w];
        probe_perm = perm_q[p_idx][w];
      end
    end
  end

  xlt_victim #(.WAYS(WAYS)) u_victim (
    .same_key (fill_same),
    .occupied (fill_occ),
    .rr_ptr   (rr_q[f_idx]),
    .way      (v_way),
    .evict    (v_evict)
  );

  // next state: flush beats everything; invalidate then refill
  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    wr_en = 1'b0;
    if (flush) begin
      vld_d = '0;
    end else begin
      if (inv_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (inv_hit[w]) vld_d[i_idx][w] = 1'b0;
        end
      end
      if (fill_en) begin
        vld_d[f_idx][v_way] = 1'b1;
        wr_en               = 1'b1;
        if (v_evict) rr_d[f_idx] = rr_q[f_idx] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  // payload: written only on refill, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[f_idx][v_way]  <= f_tag;
      frm_q[f_idx][v_way]  <= fill_frm;
      perm_q[f_idx][v_way] <= fill_perm;
    end
  end

endmodule

// File: rtl/xlt_resolve.sv
// Merges the three probes and applies the permission and dirty rules.
module xlt_resolve
  import xlt_pkg::*;
#(
  parameter  int unsigned PPN_W = 40,
  parameter  int unsigned SPAN  = LVL_BITS,
  localparam int unsigned FRM_M = PPN_W - SPAN,
  localparam int unsigned FRM_G = PPN_W - 2 * SPAN
) (
  input  logic               hit_k,
  input  logic [PPN_W-1:0]   frm_k,
  input  xlt_perm_t          perm_k,
  input  logic               hit_m,
  input  logic [FRM_M-1:0]   frm_m,
  input  xlt_perm_t          perm_m,
  input  logic               hit_g,
  input  logic [FRM_G-1:0]   frm_g,
  input  xlt_perm_t          perm_g,
  input  logic [2*SPAN-1:0]  vpn_lo,
  input  logic               is_write,
  input  logic               is_user,
  output logic               hit,
  output logic               fault,
  output logic               miss,
  output logic [PPN_W-1:0]   ppn
);

  logic      found, deny, clean;
  xlt_perm_t sel;

  always_comb begin
    found = 1'b1;
    sel   = '0;
    ppn   = '0;
    if (hit_k) begin
      sel = perm_k;
      ppn = frm_k;
    end else if (hit_m) begin
      sel = perm_m;
      ppn = {frm_m, vpn_lo[SPAN-1:0]};
    end else if (hit_g) begin
      sel = perm_g;
      ppn = {frm_g, vpn_lo};
    end else begin
      found = 1'b0;
    end
    deny  = found && ((is_user && !sel.usr) || (is_write && !sel.wr));
    clean = found && !deny && is_write && !sel.dirty;
    fault = deny;
    hit   = found && !deny && !clean;
    miss  = !found || clean;
  end

endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter  int unsigned VPN_W   = 36,
  parameter  int unsigned PPN_W   = 40,
  parameter  int unsigned SETS_4K = 16,
  parameter  int unsigned WAYS_4K = 4,
  parameter  int unsigned ENT_2M  = 8,
  parameter  int unsigned ENT_1G  = 4,
  localparam int unsigned SPAN    = LVL_BITS,
  localparam int unsigned KEY_M   = VPN_W - SPAN,
  localparam int unsigned KEY_G   = VPN_W - 2 * SPAN,
  localparam int unsigned FRM_M   = PPN_W - SPAN,
  localparam int unsigned FRM_G   = PPN_W - 2 * SPAN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             rsp_miss,
  output logic [PPN_W-1:0] rsp_ppn,
  input  logic             fill_en,
  input  logic [1:0]       fill_size,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_user,
  input  logic             fill_write,
  input  logic             fill_dirty,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             root_load
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  xlt_size_e fsz;
  xlt_perm_t fperm;
  logic      fill_k, fill_m, fill_g;

  assign fsz    = xlt_size_e'(fill_size);
  assign fperm  = '{usr: fill_user, wr: fill_write, dirty: fill_dirty};
  assign fill_k = fill_en && (fsz == SZ_4K);
  assign fill_m = fill_en && (fsz == SZ_2M);
  assign fill_g = fill_en && (fsz == SZ_1G);

  logic             hit_k, hit_m, hit_g;
  logic [PPN_W-1:0] frm_k;
  logic [FRM_M-1:0] frm_m;
  logic [FRM_G-1:0] frm_g;
  xlt_perm_t        perm_k, perm_m, perm_g;

  xlt_bank #(.KEY_W(VPN_W), .FRM_W(PPN_W), .SETS(SETS_4K), .WAYS(WAYS_4K)) u_bank_4k (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .probe_key  (lk_vpn),
    .probe_hit  (hit_k),
    .probe_frm  (frm_k),
    .probe_perm (perm_k),
    .flush      (root_load),
    .inv_en     (inv_en),
    .inv_key    (inv_vpn),
    .fill_en    (fill_k),
    .fill_key   (fill_vpn),
    .fill_frm   (fill_ppn),
    .fill_perm  (fperm)
  );

  xlt_bank #(.KEY_W(KEY_M), .FRM_W(FRM_M), .SETS(1), .WAYS(ENT_2M)) u_bank_2m (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .probe_key  (lk_vpn[VPN_W-1:SPAN]),
    .probe_hit  (hit_m),
    .probe_frm  (frm_m),
    .probe_perm (perm_m),
    .flush      (root_load),
    .inv_en     (inv_en),
    .inv_key    (inv_vpn[VPN_W-1:SPAN]),
    .fill_en    (fill_m),
    .fill_key   (fill_vpn[VPN_W-1:SPAN]),
    .fill_frm   (fill_ppn[PPN_W-1:SPAN]),
    .fill_perm  (fperm)
  );

  xlt_bank #(.KEY_W(KEY_G), .FRM_W(FRM_G), .SETS(1), .WAYS(ENT_1G)) u_bank_1g (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .probe_key  (lk_vpn[VPN_W-1:2*SPAN]),
    .probe_hit  (hit_g),
    .probe_frm  (frm_g),
    .probe_perm (perm_g),
    .flush      (root_load),
    .inv_en     (inv_en),
    .inv_key    (inv_vpn[VPN_W-1:2*SPAN]),
    .fill_en    (fill_g),
    .fill_key   (fill_vpn[VPN_W-1:2*SPAN]),
    .fill_frm   (fill_ppn[PPN_W-1:2*SPAN]),
    .fill_perm  (fperm)
  );

  logic             r_hit, r_fault, r_miss;
  logic [PPN_W-1:0] r_ppn;

  xlt_resolve #(.PPN_W(PPN_W), .SPAN(SPAN)) u_resolve (
    .hit_k    (hit_k),
    .frm_k    (frm_k),
    .perm_k   (perm_k),
    .hit_m    (hit_m),
    .frm_m    (frm_m),
    .perm_m   (perm_m),
    .hit_g    (hit_g),
    .frm_g    (frm_g),
    .perm_g   (perm_g),
    .vpn_lo   (lk_vpn[2*SPAN-1:0]),
    .is_write (lk_write),
    .is_user  (lk_user),
    .hit      (r_hit),
    .fault    (r_fault),
    .miss     (r_miss),
    .ppn      (r_ppn)
  );

  // response register
  logic vld_d, hit_d, fault_d, miss_d;
  logic vld_q, hit_q, fault_q, miss_q;
  logic [PPN_W-1:0] ppn_q;

  always_comb begin
    vld_d   = lk_valid;
    hit_d   = lk_valid && r_hit;
    fault_d = lk_valid && r_fault;
    miss_d  = lk_valid && r_miss;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      hit_q   <= hit_d;
      fault_q <= fault_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) ppn_q <= r_ppn;
  end

  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_fault = fault_q;
  assign rsp_miss  = miss_q;
  assign rsp_ppn   = ppn_q;

endmodule

// File: rtl/xlt_tlb_chk.sv
module xlt_tlb_chk #(
  parameter int unsigned VPN_W = 36,
  parameter int unsigned PPN_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_write,
  input logic             lk_user,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic             rsp_miss,
  input logic [PPN_W-1:0] rsp_ppn,
  input logic             fill_en,
  input logic [1:0]       fill_size,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             fill_user,
  input logic             fill_write,
  input logic             fill_dirty,
  input logic             inv_en,
  input logic [VPN_W-1:0] inv_vpn,
  input logic             root_load
);

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_fault, rsp_miss}));

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_miss));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    root_load ##1 lk_valid |=> rsp_miss);

  p_kernel_read_nofault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_write && !lk_user) |=> !rsp_fault);

  p_inval_removes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fill_en && !root_load) ##1 (lk_valid && (lk_vpn == $past(inv_vpn)))
    |=> rsp_miss);

  p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && (fill_size == 2'd0) && fill_user && fill_write && fill_dirty
     && !inv_en && !root_load) ##1 (lk_valid && (lk_vpn == $past(fill_vpn)))
    |=> (rsp_hit && (rsp_ppn == $past(fill_ppn, 2))));

endmodule

bind xlt_tlb xlt_tlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .lk_valid   (lk_valid),
  .lk_vpn     (lk_vpn),
  .lk_write   (lk_write),
  .lk_user    (lk_user),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .rsp_miss   (rsp_miss),
  .rsp_ppn    (rsp_ppn),
  .fill_en    (fill_en),
  .fill_size  (fill_size),
  .fill_vpn   (fill_vpn),
  .fill_ppn   (fill_ppn),
  .fill_user  (fill_user),
  .fill_write (fill_write),
  .fill_dirty (fill_dirty),
  .inv_en     (inv_en),
  .inv_vpn    (inv_vpn),
  .root_load  (root_load)
);

// File: tb/xlt_tlb_tb.sv
`timescale 1ns/1ps
module xlt_tlb_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst_n;
  logic        lk_valid, lk_write, lk_user;
  logic [35:0] lk_vpn;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss;
  logic [39:0] rsp_ppn;
  logic        fill_en, fill_user, fill_write, fill_dirty;
  logic [1:0]  fill_size;
  logic [35:0] fill_vpn;
  logic [39:0] fill_ppn;
  logic        inv_en, root_load;
  logic [35:0] inv_vpn;

  xlt_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_miss(rsp_miss), .rsp_ppn(rsp_ppn),
    .fill_en(fill_en), .fill_size(fill_size), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_user(fill_user), .fill_write(fill_write), .fill_dirty(fill_dirty),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .root_load(root_load)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference: level 0 = 4 KB, 1 = 2 MB, 2 = 1 GB
  logic [35:0] mk [3][16][8];
  logic [39:0] mf [3][16][8];
  bit          mv [3][16][8];
  bit          mu [3][16][8];
  bit          mw [3][16][8];
  bit          md [3][16][8];
  int          mrr[3][16];

  function automatic int nways(int l);
    return (l == 1) ? 8 : 4;
  endfunction

  function automatic int setof(int l, logic [35:0] v);
    return (l == 0) ? int'(v[3:0]) : 0;
  endfunction

  task automatic model_clear();
    for (int l = 0; l < 3; l++)
      for (int s = 0; s < 16; s++) begin
        mrr[l][s] = 0;
        for (int w = 0; w < 8; w++) mv[l][s][w] = 1'b0;
      end
  endtask

  task automatic model_lookup(input logic [35:0] v, input bit wr, input bit us,
                              output bit eh, output bit ef, output bit em,
                              output logic [39:0] ep);
    bit found;
    bit pu, pw, pd;
    found = 1'b0; pu = 0; pw = 0; pd = 0;
    eh = 0; ef = 0; em = 0; ep = '0;
    for (int l = 0; l < 3 && !found; l++) begin
      int s;
      s = setof(l, v);
      for (int w = 0; w < nways(l) && !found; w++) begin
        if (mv[l][s][w] && mk[l][s][w] == (v >> (9 * l))) begin
          found = 1'b1;
          pu = mu[l][s][w]; pw = mw[l][s][w]; pd = md[l][s][w];
          ep = (mf[l][s][w] << (9 * l)) | (40'(v) & ((40'd1 << (9 * l)) - 40'd1));
        end
      end
    end
    if (!found) em = 1;
    else if ((us && !pu) || (wr && !pw)) ef = 1;
    else if (wr && !pd) em = 1;
    else eh = 1;
  endtask

  task automatic model_update();
    int fl, fs, fw;
    bit evict;
    logic [35:0] key;
    fl = -1; fs = 0; fw = -1; evict = 0; key = '0;
    if (root_load) begin
      for (int l = 0; l < 3; l++)
        for (int s = 0; s < 16; s++)
          for (int w = 0; w < 8; w++) mv[l][s][w] = 1'b0;
      return;
    end
    if (fill_en && fill_size != 2'd3) begin
      fl = int'(fill_size);
      fs = setof(fl, fill_vpn);
      key = fill_vpn >> (9 * fl);
      for (int w = 0; w < nways(fl); w++)
        if (fw < 0 && mv[fl][fs][w] && mk[fl][fs][w] == key) fw = w;
      for (int w = 0; w < nways(fl); w++)
        if (fw < 0 && !mv[fl][fs][w]) fw = w;
      if (fw < 0) begin fw = mrr[fl][fs]; evict = 1; end
    end
    if (inv_en) begin
      for (int l = 0; l < 3; l++) begin
        int s;
        s = setof(l, inv_vpn);
        for (int w = 0; w < nways(l); w++)
          if (mv[l][s][w] && mk[l][s][w] == (inv_vpn >> (9 * l))) mv[l][s][w] = 1'b0;
      end
    end
    if (fl >= 0) begin
      mv[fl][fs][fw] = 1'b1;
      mk[fl][fs][fw] = key;
      mf[fl][fs][fw] = fill_ppn >> (9 * fl);
      mu[fl][fs][fw] = fill_user;
      mw[fl][fs][fw] = fill_write;
      md[fl][fs][fw] = fill_dirty;
      if (evict) mrr[fl][fs] = (mrr[fl][fs] + 1) % nways(fl);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_vpn = '0; lk_write = 0; lk_user = 0;
    fill_en = 0; fill_size = 2'd0; fill_vpn = '0; fill_ppn = '0;
    fill_user = 0; fill_write = 0; fill_dirty = 0;
    inv_en = 0; inv_vpn = '0; root_load = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // one clock: expectation from pre-edge state, model update, compare after edge
  task automatic cycle(input string tag);
    bit eh, ef, em, ev;
    logic [39:0] ep;
    bit bad;
    ev = lk_valid;
    if (ev) model_lookup(lk_vpn, lk_write, lk_user, eh, ef, em, ep);
    else begin eh = 0; ef = 0; em = 0; ep = '0; end
    model_update();
    @(posedge clk);
    #1;
    checks++;
    bad = (rsp_valid !== ev) || (rsp_hit !== eh) || (rsp_fault !== ef) || (rsp_miss !== em);
    if (eh && rsp_ppn !== ep) bad = 1;
    if (bad) begin
      failures++;
      $display("FAIL %s: v/h/f/m act=%b%b%b%b ppn=%h exp=%b%b%b%b ppn=%h",
               tag, rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_ppn,
               ev, eh, ef, em, ep);
    end
    idle_inputs();
  endtask

  task automatic look(input string tag, input logic [35:0] v, input bit wr, input bit us);
    lk_valid = 1; lk_vpn = v; lk_write = wr; lk_user = us;
    cycle(tag);
  endtask

  task automatic put(input logic [1:0] sz, input logic [35:0] v, input logic [39:0] p,
                     input bit u, input bit w, input bit d);
    fill_en = 1; fill_size = sz; fill_vpn = v; fill_ppn = p;
    fill_user = u; fill_write = w; fill_dirty = d;
  endtask

  task automatic fill(input string tag, input logic [1:0] sz, input logic [35:0] v,
                      input logic [39:0] p, input bit u, input bit w, input bit d);
    put(sz, v, p, u, w, d);
    cycle(tag);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog: act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle_inputs();
    model_clear();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_fault !== 0 || rsp_miss !== 0) begin
      failures++;
      $display("FAIL R1 reset outputs: act=%b%b%b%b exp=0000",
               rsp_valid, rsp_hit, rsp_fault, rsp_miss);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cycle("R1");
    look("R1", 36'h0_0000_0000, 0, 0);
    look("R1", 36'h0_1234_5678, 0, 1);

    // R3: 4 KB refill and hit, several sets
    fill("R3", 2'd0, 36'h0_0000_1235, 40'hAB_CDEF_0123, 1, 1, 1);
    look("R3", 36'h0_0000_1235, 0, 1);
    look("R3", 36'h0_0000_1235, 1, 1);
    fill("R3", 2'd0, 36'h9_8765_432A, 40'h01_0203_0405, 1, 1, 1);
    look("R3", 36'h9_8765_432A, 0, 0);
    look("R3", 36'h9_8765_432B, 0, 0);
    // R2: refill and lookup of the same page in one cycle
    lk_valid = 1; lk_vpn = 36'h0_0000_2220; put(2'd0, 36'h0_0000_2220, 40'h55_5555_5555, 1, 1, 1);
    cycle("R2");
    look("R2", 36'h0_0000_2220, 0, 0);

    // R4: 2 MB pages, low frame bits ignored
    fill("R4", 2'd1, 36'h0_00A0_0200, 40'h12_3456_71FF, 1, 1, 1);
    look("R4", 36'h0_00A0_03AB, 0, 1);
    look("R4", 36'h0_00A0_0200, 1, 1);
    look("R4", 36'h0_00A0_0400, 0, 1);

    // R5: 1 GB pages
    fill("R5", 2'd2, 36'h5_0000_0000, 40'hF0_0003_FFFF, 1, 1, 1);
    look("R5", 36'h5_0003_1234, 0, 0);
    look("R5", 36'h5_0004_0000, 0, 0);

    // R6: permission faults
    fill("R6", 2'd0, 36'h0_0000_3001, 40'h00_0000_0AAA, 0, 1, 1);
    look("R6", 36'h0_0000_3001, 0, 1);
    look("R6", 36'h0_0000_3001, 0, 0);
    fill("R6", 2'd0, 36'h0_0000_3002, 40'h00_0000_0BBB, 1, 0, 0);
    look("R6", 36'h0_0000_3002, 1, 1);
    look("R6", 36'h0_0000_3002, 0, 1);

    // R7: write to clean page misses; refill in place with dirty set
    fill("R7", 2'd0, 36'h0_0000_3003, 40'h00_0000_0CCC, 1, 1, 0);
    look("R7", 36'h0_0000_3003, 1, 1);
    look("R7", 36'h0_0000_3003, 0, 1);
    fill("R10", 2'd0, 36'h0_0000_3003, 40'h00_0000_0CCD, 1, 1, 1);
    look("R7", 36'h0_0000_3003, 1, 1);

    // R10: replacement in set 7
    for (int i = 0; i < 6; i++)
      fill("R10", 2'd0, 36'h0_0007_0007 + 36'(i * 16), 40'h00_0010_0000 + 40'(i), 1, 1, 1);
    for (int i = 0; i < 6; i++) look("R10", 36'h0_0007_0007 + 36'(i * 16), 0, 0);

    // R9: invalidate a 2 MB page with a same-cycle lookup and refill
    lk_valid = 1; lk_vpn = 36'h0_00A0_0311; inv_en = 1; inv_vpn = 36'h0_00A0_0311;
    put(2'd0, 36'h0_0000_4444, 40'h00_0000_4444, 1, 1, 1);
    cycle("R9");
    look("R9", 36'h0_00A0_0311, 0, 0);
    look("R9", 36'h0_0000_4444, 0, 0);
    look("R9", 36'h0_0000_1235, 0, 0);
    inv_en = 1; inv_vpn = 36'h5_0000_0001; cycle("R9");
    look("R9", 36'h5_0003_1234, 0, 0);
    look("R9", 36'h9_8765_432A, 0, 0);

    // R11: overlapping sizes
    fill("R11", 2'd0, 36'h0_0300_0005, 40'h00_0000_7777, 1, 1, 1);
    fill("R11", 2'd1, 36'h0_0300_0000, 40'h00_8800_0000, 1, 1, 1);
    look("R11", 36'h0_0300_0005, 0, 0);
    look("R11", 36'h0_0300_0006, 0, 0);
    fill("R11", 2'd2, 36'h0_0300_0000, 40'h44_0000_0000, 1, 1, 1);
    look("R11", 36'h0_0300_0006, 0, 0);
    look("R11", 36'h0_0304_0000, 0, 0);

    // R12: size code 3 ignored
    fill("R12", 2'd3, 36'h0_0000_6666, 40'h00_0000_6666, 1, 1, 1);
    look("R12", 36'h0_0000_6666, 0, 0);

    // R8: root load with same-cycle lookup and refill
    lk_valid = 1; lk_vpn = 36'h0_0000_1235; root_load = 1;
    put(2'd0, 36'h0_0000_8888, 40'h00_0000_8888, 1, 1, 1);
    cycle("R8");
    look("R8", 36'h0_0000_1235, 0, 0);
    look("R8", 36'h0_0000_8888, 0, 0);
    look("R8", 36'h0_0300_0006, 0, 0);

    // mixed random traffic on a small address pool
    for (int n = 0; n < 4000; n++) begin
      logic [35:0] a;
      a = {16'($urandom_range(0, 3)), 9'($urandom_range(0, 3)), 2'b00, 9'($urandom_range(0, 40))};
      if ($urandom_range(0, 1) == 1) begin
        lk_valid = 1; lk_vpn = a;
        lk_write = $urandom_range(0, 1) == 1; lk_user = $urandom_range(0, 1) == 1;
      end
      if ($urandom_range(0, 2) == 0)
        put(2'($urandom_range(0, 3)),
            {16'($urandom_range(0, 3)), 9'($urandom_range(0, 3)), 2'b00, 9'($urandom_range(0, 40))},
            {$urandom, 8'($urandom)}, $urandom_range(0, 3) != 0,
            $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 9) == 0) begin
        inv_en = 1; inv_vpn = {16'($urandom_range(0, 3)), 9'($urandom_range(0, 3)), 2'b00, 9'($urandom_range(0, 40))};
      end
      if ($urandom_range(0, 299) == 0) root_load = 1;
      cycle("R2");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule